// File: doc/BRIEF.md
# Run-length and size symbol generator

This block turns one 64-coefficient block, already in zig-zag order with the DC difference at position 0, into the sequence of entropy-coding events that a table-driven coder consumes. Each event is a record of an 8-bit symbol, a flag that selects the DC or the AC table, the amplitude bits and their length. The first record of every block is the DC event. It is followed by the AC run/size events, by zero-run extensions (ZRL) for long gaps and, when the block ends in zeros, by an end-of-block marker.

The caller supplies the coefficients together with a left-aligned map of the nonzero AC positions. The generator does not step through the coefficients one at a time. It counts the leading zeros of the remaining map to jump straight to the next flagged coefficient, so every output cycle carries a record. Code lookup and bit packing live downstream.

Both streams use valid/ready. A block is taken on a cycle with `blk_valid` and `blk_ready` both high, and `blk_ready` stays low from then until the last record of that block has been taken. A record transfers on a cycle with `rec_valid` and `rec_ready` both high. While `rec_ready` is low the current record is held unchanged and no internal state advances.

Top module: `rle_symbol_gen`

## Requirements
- R1: The size category of a 16-bit signed value is the number of significant bits in its magnitude (16 minus the leading-zero count of the 16-bit absolute value). Zero has category 0. The record length field `rec_len` equals this category for DC and AC events.
- R2: The amplitude of a positive value is the value itself. For a negative value it is the bitwise complement of its magnitude, keeping only the low category bits. All higher bits of `rec_amp` are zero.
- R3: The first record of every block is the DC event: `rec_is_ac`=0, `rec_sym` = category of coefficient 0, with the amplitude of coefficient 0.
- R4: AC events come out in ascending position order, one for each flagged position, with `rec_is_ac`=1 and `rec_sym` = run*16 + category. Here run is the number of positions since the previous coded coefficient, or since position 0, less any ZRL already emitted. AC coefficients are expected to have category 15 or less.
- R5: While a pending run exceeds 15, a ZRL record is emitted (`rec_sym`=0xF0, `rec_is_ac`=1, `rec_len`=0, `rec_amp`=0) and the run drops by 16. A run of exactly 15 emits no ZRL.
- R6: When the last coded coefficient is not at position 63, an end-of-block record (`rec_sym`=0x00, `rec_is_ac`=1, `rec_len`=0, `rec_amp`=0) closes the block. When position 63 is coded, no end-of-block follows.
- R7: A block with an empty AC map yields exactly two records: the DC event and the end-of-block.
- R8: While `rec_valid` is high and `rec_ready` is low, the record fields stay stable and `rec_valid` stays high.
- R9: After reset, `blk_ready`=1 and `rec_valid`=0. `blk_ready` is low from the cycle after a block is accepted until the cycle after its last record is taken, and never high while `rec_valid` is high.
- R10: Bit 63-k of `blk_map` flags AC position k (k = 1..63). Only flagged positions are coded. A nonzero coefficient whose bit is clear counts as zero in the run and produces no record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A block is offered |
| blk_ready | output | 1 | Generator idle, block can be taken |
| blk_coef | input | 1024 | 64 signed 16-bit coefficients; position k at bits 16k+15..16k |
| blk_map | input | 63 | Nonzero AC map, bit 63-k for position k |
| rec_valid | output | 1 | A record is presented |
| rec_ready | input | 1 | Downstream takes the record |
| rec_sym | output | 8 | DC category, AC run/size, 0xF0 or 0x00 |
| rec_is_ac | output | 1 | 1 selects the AC table, 0 the DC table |
| rec_amp | output | 16 | Amplitude bits, right-aligned |
| rec_len | output | 5 | Number of valid amplitude bits |

## Verification
A run counter that has drifted shows up in the high nibble of the next AC symbol, or as a missing or extra ZRL. A bitmap shifted by the wrong amount selects the wrong coefficient, which corrupts the category and amplitude of the very next record. An error in the position counter appears only at the block's end, as a wrong presence or absence of the end-of-block and of the `blk_ready` return. Stalls are mixed into most vectors, so a state that advances without a handshake surfaces as a changed record during a held cycle or as a record that is lost.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DC,
    ST_ZRL,
    ST_AC,
    ST_EOB
  } gen_state_e;

  localparam int        RUN_MAX = 15;
  localparam logic [7:0] SYM_ZRL = 8'hF0;
  localparam logic [7:0] SYM_EOB = 8'h00;
endpackage

// File: rtl/rle_lzc.sv
module rle_lzc #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    cnt = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/rle_category.sv
module rle_category #(
  parameter int COEF_W = 16,
  localparam int CAT_W = $clog2(COEF_W + 1)
) (
  input  logic [COEF_W-1:0] value,
  output logic [CAT_W-1:0]  cat,
  output logic [COEF_W-1:0] amp
);
  logic              neg;
  logic [COEF_W-1:0] mag;
  logic [CAT_W-1:0]  lead;
  logic [COEF_W-1:0] keep;

  assign neg = value[COEF_W-1];
  assign mag = neg ? COEF_W'(~value + 1'b1) : value;

  rle_lzc #(.W(COEF_W)) i_mag_lzc (.vec(mag), .cnt(lead));

  assign cat  = CAT_W'(COEF_W) - lead;
  assign keep = ~({COEF_W{1'b1}} << cat);
  assign amp  = neg ? (~mag & keep) : value;

  // R2: no amplitude bit above the category
  always_comb begin
    if (cat < CAT_W'(COEF_W))
      assert_amp_fits_R2: assert ((amp & ~keep) == '0);
  end
endmodule

// File: rtl/rle_symbol_gen.sv
module rle_symbol_gen
  import rle_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int NCOEF  = 64,
  localparam int CAT_W = $clog2(COEF_W + 1),
  localparam int AC_N  = NCOEF - 1,
  localparam int IDX_W = $clog2(NCOEF),
  localparam int SYM_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blk_valid,
  output logic                    blk_ready,
  input  logic [NCOEF*COEF_W-1:0] blk_coef,
  input  logic [AC_N-1:0]         blk_map,
  output logic                    rec_valid,
  input  logic                    rec_ready,
  output logic [SYM_W-1:0]        rec_sym,
  output logic                    rec_is_ac,
  output logic [COEF_W-1:0]       rec_amp,
  output logic [CAT_W-1:0]        rec_len
);
  gen_state_e              state_q;
  logic [NCOEF*COEF_W-1:0] coef_q;
  logic [AC_N-1:0]         map_q;
  logic [IDX_W:0]          pos_q;
  logic [IDX_W-1:0]        run_q;
  logic [IDX_W-1:0]        idx_q;

  logic [COEF_W-1:0] sel_coef;
  logic [CAT_W-1:0]  sel_cat;
  logic [COEF_W-1:0] sel_amp;
  logic [IDX_W-1:0]  map_lead;
  logic [IDX_W:0]    scan_tgt;
  gen_state_e        scan_state;
  logic [IDX_W-1:0]  run_less;
  logic              fire;

  assign sel_coef = coef_q[int'(idx_q)*COEF_W +: COEF_W];

  rle_category #(.COEF_W(COEF_W)) i_cat (
    .value(sel_coef), .cat(sel_cat), .amp(sel_amp)
  );

  rle_lzc #(.W(AC_N)) i_map_lzc (.vec(map_q), .cnt(map_lead));

  assign fire     = rec_valid && rec_ready;
  assign scan_tgt = pos_q + {1'b0, map_lead};
  assign run_less = run_q - IDX_W'(RUN_MAX + 1);

  always_comb begin
    if (map_q == '0)
      scan_state = (pos_q != (IDX_W+1)'(NCOEF)) ? ST_EOB : ST_IDLE;
    else if (int'(map_lead) > RUN_MAX)
      scan_state = ST_ZRL;
    else
      scan_state = ST_AC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      coef_q  <= '0;
      map_q   <= '0;
      pos_q   <= '0;
      run_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (blk_valid) begin
          coef_q  <= blk_coef;
          map_q   <= blk_map;
          pos_q   <= (IDX_W+1)'(1);
          idx_q   <= '0;
          state_q <= ST_DC;
        end
        ST_DC, ST_AC: if (fire) begin
          state_q <= scan_state;
          if (map_q != '0) begin
            run_q <= map_lead;
            idx_q <= scan_tgt[IDX_W-1:0];
            pos_q <= scan_tgt + 1'b1;
            map_q <= (map_q << map_lead) << 1;
          end
        end
        ST_ZRL: if (fire) begin
          run_q <= run_less;
          if (int'(run_less) <= RUN_MAX) state_q <= ST_AC;
        end
        ST_EOB: if (fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rec_sym   = SYM_EOB;
    rec_is_ac = 1'b1;
    rec_amp   = '0;
    rec_len   = '0;
    unique case (state_q)
      ST_DC: begin
        rec_sym   = SYM_W'(sel_cat);
        rec_is_ac = 1'b0;
        rec_amp   = sel_amp;
        rec_len   = sel_cat;
      end
      ST_AC: begin
        rec_sym = {run_q[3:0], 4'b0000} + SYM_W'(sel_cat);
        rec_amp = sel_amp;
        rec_len = sel_cat;
      end
      ST_ZRL:  rec_sym = SYM_ZRL;
      default: rec_sym = SYM_EOB;
    endcase
  end

  assign rec_valid = (state_q != ST_IDLE);
  assign blk_ready = (state_q == ST_IDLE);

  // R8: a stalled record is held
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable({rec_sym, rec_is_ac, rec_amp, rec_len}));

  // R3: DC record directly after acceptance
  assert_dc_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready |=> rec_valid && !rec_is_ac);

  // R5: ZRL only while the pending run is above the limit
  assert_zrl_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ZRL |-> int'(run_q) > RUN_MAX);

  // R4: AC length agrees with the size nibble and is nonzero
  assert_ac_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_AC |-> rec_len == CAT_W'(rec_sym[3:0]) && rec_len != '0);

  // R6: taking the end-of-block returns the generator to idle
  assert_eob_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && rec_is_ac && rec_sym == SYM_EOB |=> blk_ready && !rec_valid);
endmodule

// File: tb/test_rle_symbol_gen.sv
`timescale 1ns/1ps
module test_rle_symbol_gen;
  logic          clk = 0;
  logic          rst_n = 0;
  logic          blk_valid = 0;
  logic          blk_ready;
  logic [1023:0] blk_coef = '0;
  logic [62:0]   blk_map = '0;
  logic          rec_valid;
  logic          rec_ready = 0;
  logic [7:0]    rec_sym;
  logic          rec_is_ac;
  logic [15:0]   rec_amp;
  logic [4:0]    rec_len;

  always #4 clk = ~clk;

  rle_symbol_gen i_rle_symbol_gen (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_coef(blk_coef), .blk_map(blk_map), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_sym(rec_sym), .rec_is_ac(rec_is_ac),
    .rec_amp(rec_amp), .rec_len(rec_len)
  );

  int checks = 0;
  int bad = 0;

  typedef struct packed {
    logic [15:0] dc;
    logic [7:0]  p0; logic [15:0] v0;
    logic [7:0]  p1; logic [15:0] v1;
    logic [7:0]  p2; logic [15:0] v2;
    logic [7:0]  nrec;
    logic [1:0]  rmode;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'd5,     8'd0,  16'd0,     8'd0,  16'd0,     8'd0,  16'd0,   8'd2, 2'd0},
    '{-16'sd3,   8'd1,  16'd1,     8'd0,  16'd0,     8'd0,  16'd0,   8'd3, 2'd1},
    '{16'd0,     8'd17, -16'sd7,   8'd0,  16'd0,     8'd0,  16'd0,   8'd4, 2'd2},
    '{16'd100,   8'd63, 16'd2,     8'd0,  16'd0,     8'd0,  16'd0,   8'd5, 2'd1},
    '{-16'sd1024,8'd1,  16'd1023,  8'd2,  -16'sd1,   8'd40, 16'd300, 8'd7, 2'd2},
    '{16'd32767, 8'd33, -16'sd32767,8'd34,16'd16384, 8'd0,  16'd0,   8'd6, 2'd0},
    '{16'h8000,  8'd16, 16'd1,     8'd0,  16'd0,     8'd0,  16'd0,   8'd3, 2'd1},
    '{16'd0,     8'd63, -16'sd1,   8'd62, 16'd1,     8'd0,  16'd0,   8'd6, 2'd2}
  };

  logic signed [15:0] coef [64];
  logic [63:0]        ignore_mask;
  logic [29:0]        exp_r [128];
  int                 exp_k [128];
  int                 exp_n;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int cat_of(input logic signed [15:0] v);
    int a = (v < 0) ? -int'(v) : int'(v);
    int c = 0;
    while (a > 0) begin c++; a = a >> 1; end
    return c;
  endfunction

  function automatic logic [15:0] amp_of(input logic signed [15:0] v);
    int a = (v < 0) ? -int'(v) : int'(v);
    int c = cat_of(v);
    if (v >= 0) return v;
    return 16'((~a) & ((1 << c) - 1));
  endfunction

  task automatic push(input logic [7:0] s, input bit ac, input logic [15:0] a, input int l, input int k);
    exp_r[exp_n] = {s, ac, a, 5'(l)};
    exp_k[exp_n] = k;
    exp_n++;
  endtask

  task automatic build_model();
    int run = 0;
    int last = 0;
    exp_n = 0;
    push(8'(cat_of(coef[0])), 1'b0, amp_of(coef[0]), cat_of(coef[0]), 0);
    for (int k = 1; k < 64; k++) begin
      if (blk_map[63-k]) begin
        while (run > 15) begin push(8'hF0, 1'b1, 16'h0, 0, 2); run -= 16; end
        push(8'(run*16 + cat_of(coef[k])), 1'b1, amp_of(coef[k]), cat_of(coef[k]), 1);
        run = 0; last = k;
      end else run++;
    end
    if (last != 63) push(8'h00, 1'b1, 16'h0, 0, 3);
  endtask

  task automatic run_block(input string tag, input int rmode, input int want);
    int got = 0;
    int cyc = 0;
    bit stalled = 0;
    bit overlap = 0;
    logic [29:0] held = '0;
    logic [29:0] cur;
    string kt;
    for (int k = 0; k < 64; k++) blk_coef[k*16 +: 16] = coef[k];
    for (int k = 1; k < 64; k++) blk_map[63-k] = (coef[k] != 0) && !ignore_mask[k];
    build_model();
    rec_ready = 0;
    @(negedge clk);
    blk_valid = 1;
    @(negedge clk);
    blk_valid = 0;
    chk(blk_ready == 0, {"R9 busy after accept ", tag}, 32'(blk_ready), 32'd0);
    while (cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (blk_ready && !rec_valid) break;
      if (rec_valid && blk_ready) overlap = 1;
      case (rmode)
        1: rec_ready = (cyc % 2) == 0;
        2: rec_ready = (cyc % 3) != 0;
        default: rec_ready = 1;
      endcase
      #1;
      cur = {rec_sym, rec_is_ac, rec_amp, rec_len};
      if (stalled)
        chk(rec_valid && cur == held, {"R8 held record ", tag}, 32'(cur), 32'(held));
      if (rec_valid && rec_ready) begin
        if (got < exp_n) begin
          case (exp_k[got])
            0: kt = "R3 R1 R2 dc";
            1: kt = "R4 R1 R2 ac";
            2: kt = "R5 zrl";
            default: kt = "R6 eob";
          endcase
          chk(cur == exp_r[got], {kt, " ", tag}, 32'(cur), 32'(exp_r[got]));
        end else
          chk(0, {"R6 extra record ", tag}, 32'(cur), 32'h0);
        got++;
        stalled = 0;
      end else if (rec_valid) begin
        stalled = 1;
        held = cur;
      end
    end
    rec_ready = 0;
    chk(got == want && got == exp_n, {"R6 R5 record count ", tag}, 32'(got), 32'(want));
    chk(!overlap && blk_ready && !rec_valid, {"R9 idle after block ", tag}, 32'({overlap, blk_ready, rec_valid}), 32'b010);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    ignore_mask = '0;
    repeat (3) @(negedge clk);
    chk(blk_ready == 1 && rec_valid == 0, "R9 reset state", 32'({blk_ready, rec_valid}), 32'b10);
    rst_n = 1;
    @(negedge clk);
    chk(blk_ready == 1 && rec_valid == 0, "R9 after reset release", 32'({blk_ready, rec_valid}), 32'b10);

    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < 64; k++) coef[k] = 0;
      coef[0] = VECS[t].dc;
      if (VECS[t].p0 != 0) coef[VECS[t].p0] = VECS[t].v0;
      if (VECS[t].p1 != 0) coef[VECS[t].p1] = VECS[t].v1;
      if (VECS[t].p2 != 0) coef[VECS[t].p2] = VECS[t].v2;
      run_block((t == 0) ? "R7 empty ac" : $sformatf("vec%0d", t), int'(VECS[t].rmode), int'(VECS[t].nrec));
    end

    // full block: every AC flagged, position 63 coded, no end-of-block
    coef[0] = 7;
    for (int k = 1; k < 64; k++) coef[k] = (k % 2 == 1) ? 16'(k) : -16'(k);
    run_block("R4 R6 full block", 2, 64);

    // unflagged nonzero coefficient is skipped
    for (int k = 0; k < 64; k++) coef[k] = 0;
    coef[0] = -2; coef[5] = 9; coef[10] = 2;
    ignore_mask[5] = 1;
    run_block("R10 unflagged coef", 1, 3);
    ignore_mask = '0;

    // a second empty block right after, back-to-back
    for (int k = 0; k < 64; k++) coef[k] = 0;
    coef[0] = 0;
    run_block("R7 zero dc", 0, 2);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule